// File: doc/BRIEF.md
# Edge-Qualified Watchdog Timer with Selectable Time Base

This block is a watchdog that never stops counting. An 8-bit down-counter is loaded from a preset register. It steps once per unit of time, and the unit is either one second or one minute. The second comes from an external one-cycle tick pulse. The minute is built inside the block by dividing that tick. Software keeps the system alive by rewriting the preset. Each such write reloads the counter and restarts the minute divider.

When the count runs out, the block latches an event flag. It fires a fixed-width system-reset pulse only at the moment that flag goes from clear to set while the output-enable bit is on. Turning the output on after the flag is already set causes no reset. A later expiry while the flag is still set causes no reset either. Clearing output enable therefore disarms the reset but leaves the timer running.

Four byte-wide registers share one write port and a combinational read port. They hold the preset, the control byte (time-base bit), the output-enable byte, and a status byte that carries the event flag and is cleared by writing a 1.

Top module: `edge_wdt`

## Requirements
- R1: After reset, reading address 0 returns 60, address 1 returns 0x01, address 2 returns 0x00 and address 3 returns 0x00. event_flag and sys_rst are low.
- R2: When bit 0 of the control register (address 1) is 1, a preset write of N (1..255) makes event_flag rise on exactly the Nth tick_sec pulse after the write. This also applies after reset with the default preset.
- R3: When bit 0 of the control register is 0, each count unit lasts MIN_DIV (default 60) tick_sec pulses. event_flag rises on tick N*MIN_DIV after a preset write of N.
- R4: A preset write reloads the counter and restarts the minute divider, whatever the counter and divider held before.
- R5: The counter runs and event_flag sets whatever the value of bit 1 of the output-enable register (address 2). With that bit clear, sys_rst stays low.
- R6: If bit 1 of address 2 is set in the cycle the counter expires and event_flag was clear, sys_rst goes high at the same clock edge as event_flag and stays high for exactly RST_PULSE (default 4) cycles.
- R7: Setting bit 1 of address 2 while event_flag is already set produces no sys_rst.
- R8: A further expiry while event_flag is still set produces no sys_rst.
- R9: Writing address 3 with bit 0 = 1 clears event_flag. Writing it with bit 0 = 0 leaves event_flag unchanged. Address 3 reads event_flag in bit 0 and zero elsewhere.
- R10: After an expiry the counter holds at zero and raises no further event until the preset is rewritten. A preset of 0 never expires.
- R11: Addresses 0, 1 and 2 read back the full byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sec | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read: 0 preset, 1 control, 2 output enable, 3 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational readback of the selected register |
| event_flag | output | 1 | Latched expiry flag |
| sys_rst | output | 1 | System-reset pulse |

## Verification
Corrupted counter or divider state shows up as event_flag rising one or more ticks early or late. The bench therefore sweeps many presets and time bases and checks the exact tick count to expiry, bracketing the expected tick on both sides. A wrong edge or enable qualification shows up as sys_rst pulses where none are allowed, or with a width other than RST_PULSE. To catch this, the bench counts every sys_rst cycle over the whole run and compares the total after each scenario. Register corruption appears immediately on the readback port.

// File: rtl/edge_wdt_pkg.sv
package edge_wdt_pkg;
    typedef enum logic [1:0] {
        SEL_PRESET = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_OUTEN  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    localparam int BASE_SEC_BIT = 0;
    localparam int OUT_EN_BIT   = 1;
    localparam int EVT_BIT      = 0;
endpackage

// File: rtl/edge_wdt_regs.sv
module edge_wdt_regs
    import edge_wdt_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PRESET_RST = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              event_q,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] preset,
    output logic              load,
    output logic              sec_base,
    output logic              out_en,
    output logic              evt_clr
);
    typedef struct packed {
        logic [DATA_W-1:0] preset;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] outen;
    } regs_t;

    regs_t r_d, r_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        r_d     = r_q;
        load    = 1'b0;
        evt_clr = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_PRESET: begin
                    r_d.preset = wr_data;
                    load       = 1'b1;
                end
                SEL_CTRL:   r_d.ctrl  = wr_data;
                SEL_OUTEN:  r_d.outen = wr_data;
                SEL_STATUS: evt_clr   = wr_data[EVT_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.preset <= DATA_W'(PRESET_RST);
            r_q.ctrl   <= DATA_W'(1) << BASE_SEC_BIT;
            r_q.outen  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_PRESET: rd_data = r_q.preset;
            SEL_CTRL:   rd_data = r_q.ctrl;
            SEL_OUTEN:  rd_data = r_q.outen;
            SEL_STATUS: rd_data[EVT_BIT] = event_q;
            default: ;
        endcase
    end

    assign preset   = wr_data;
    assign sec_base = r_q.ctrl[BASE_SEC_BIT];
    assign out_en   = r_q.outen[OUT_EN_BIT];

    // R11: a written byte is what the register holds afterwards
    a_r11_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL) |=> (r_q.ctrl == $past(wr_data)));
endmodule

// File: rtl/edge_wdt_timebase.sv
module edge_wdt_timebase #(
    parameter int MIN_DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_sec,
    input  logic sec_base,
    input  logic load,
    output logic unit_tick
);
    localparam int DIV_W = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MIN_DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;
    logic             wrap;

    assign wrap = (div_q == DIV_LAST);

    always_comb begin
        div_d = div_q;
        if (load) begin
            div_d = '0;
        end else if (tick_sec) begin
            div_d = wrap ? '0 : div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign unit_tick = tick_sec && (sec_base || wrap);

    // R3: the divider never leaves its range
    a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_LAST);
    // R4: a preset write restarts the divider
    a_r4_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (div_q == '0));
endmodule

// File: rtl/edge_wdt_counter.sv
module edge_wdt_counter #(
    parameter int DATA_W     = 8,
    parameter int PRESET_RST = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] preset,
    input  logic              unit_tick,
    output logic              expire
);
    logic [DATA_W-1:0] cnt_d, cnt_q;
    logic              at_zero;

    assign at_zero = (cnt_q == '0);

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load) begin
            cnt_d = preset;
        end else if (unit_tick && !at_zero) begin
            cnt_d  = cnt_q - DATA_W'(1);
            expire = (cnt_q == DATA_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= DATA_W'(PRESET_RST);
        else        cnt_q <= cnt_d;
    end

    // R2: without a load the count only holds or steps down by one
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DATA_W'(1)));
    // R10: an expired counter stays at zero until reloaded
    a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/edge_wdt_event.sv
module edge_wdt_event #(
    parameter int RST_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic evt_clr,
    input  logic out_en,
    output logic event_q,
    output logic sys_rst
);
    localparam int PW = $clog2(RST_PULSE + 1);

    typedef struct packed {
        logic          evt;
        logic [PW-1:0] pulse;
    } ev_t;

    ev_t s_d, s_q;
    logic rise;

    assign rise = expire && !s_q.evt;

    always_comb begin
        s_d = s_q;
        if (expire)       s_d.evt = 1'b1;
        else if (evt_clr) s_d.evt = 1'b0;

        if (rise && out_en)       s_d.pulse = PW'(RST_PULSE);
        else if (s_q.pulse != '0) s_d.pulse = s_q.pulse - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign event_q = s_q.evt;
    assign sys_rst = (s_q.pulse != '0);

    // R6: a reset pulse starts only with the event rising while enabled
    a_r6_rise_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> ($rose(event_q) && $past(out_en)));
    // R8: an already-set flag never starts a reset
    a_r8_no_second: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(event_q) && event_q) |-> !$rose(sys_rst));
    // R9: the flag drops only after a clear write
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(event_q) |-> $past(evt_clr));
endmodule

// File: rtl/edge_wdt.sv
module edge_wdt
    import edge_wdt_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MIN_DIV    = 60,
    parameter int RST_PULSE  = 4,
    parameter int PRESET_RST = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sec,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              event_flag,
    output logic              sys_rst
);
    logic [DATA_W-1:0] preset;
    logic              load, sec_base, out_en, evt_clr;
    logic              unit_tick, expire, event_q;

    edge_wdt_regs #(.DATA_W(DATA_W), .PRESET_RST(PRESET_RST)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .event_q(event_q), .rd_data(rd_data),
        .preset(preset), .load(load), .sec_base(sec_base),
        .out_en(out_en), .evt_clr(evt_clr)
    );

    edge_wdt_timebase #(.MIN_DIV(MIN_DIV)) i_timebase (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec),
        .sec_base(sec_base), .load(load), .unit_tick(unit_tick)
    );

    edge_wdt_counter #(.DATA_W(DATA_W), .PRESET_RST(PRESET_RST)) i_counter (
        .clk(clk), .rst_n(rst_n), .load(load), .preset(preset),
        .unit_tick(unit_tick), .expire(expire)
    );

    edge_wdt_event #(.RST_PULSE(RST_PULSE)) i_event (
        .clk(clk), .rst_n(rst_n), .expire(expire), .evt_clr(evt_clr),
        .out_en(out_en), .event_q(event_q), .sys_rst(sys_rst)
    );

    assign event_flag = event_q;

    // R5: with the output disabled no reset pulse begins
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !sys_rst) |=> !sys_rst);
endmodule

// File: tb/test_edge_wdt.sv
module test_edge_wdt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_sec = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       event_flag, sys_rst;

    int errors = 0;
    int checks = 0;
    int rst_cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    edge_wdt i_edge_wdt (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .event_flag(event_flag), .sys_rst(sys_rst)
    );

    always @(negedge clk) if (rst_n && sys_rst) rst_cycles++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_sec = 1'b1;
            @(negedge clk);
            tick_sec = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // arm a countdown of p units, check event just before and at expiry
    task automatic expiry(input int p, input bit sec, input string req);
        int unit;
        unit = sec ? 1 : 60;
        wr(2'd1, sec ? 8'h01 : 8'h00);
        wr(2'd3, 8'h01);
        wr(2'd0, 8'(p));
        ticks(p * unit - 1);
        chk(event_flag == 1'b0, req, event_flag, 0);
        ticks(1);
        chk(event_flag == 1'b1, req, event_flag, 1);
    endtask

    initial begin
        #1_900_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd(2'd0, v); chk(v == 8'd60, "R1", v, 60);
        rd(2'd1, v); chk(v == 8'h01, "R1", v, 1);
        rd(2'd2, v); chk(v == 8'h00, "R1", v, 0);
        rd(2'd3, v); chk(v == 8'h00, "R1", v, 0);
        chk(!event_flag && !sys_rst, "R1", {event_flag, sys_rst}, 0);

        // R2 default countdown from reset: 60 seconds
        ticks(59);
        chk(event_flag == 1'b0, "R2", event_flag, 0);
        ticks(1);
        chk(event_flag == 1'b1, "R2", event_flag, 1);

        // R11 readback
        wr(2'd0, 8'hA5); rd(2'd0, v); chk(v == 8'hA5, "R11", v, 8'hA5);
        wr(2'd1, 8'hFE); rd(2'd1, v); chk(v == 8'hFE, "R11", v, 8'hFE);
        wr(2'd2, 8'h5D); rd(2'd2, v); chk(v == 8'h5D, "R11", v, 8'h5D);
        wr(2'd2, 8'h00);

        // R2 seconds sweep, R5 output disabled throughout
        base = rst_cycles;
        for (int p = 1; p <= 40; p++) expiry(p, 1'b1, "R2");
        expiry(255, 1'b1, "R2");
        chk(rst_cycles == base, "R5", rst_cycles - base, 0);

        // R3 minute base
        for (int p = 1; p <= 3; p++) expiry(p, 1'b0, "R3");

        // R4 reload restarts counter (seconds) and divider (minutes)
        wr(2'd1, 8'h01); wr(2'd3, 8'h01); wr(2'd0, 8'd5);
        ticks(3); wr(2'd0, 8'd5); ticks(4);
        chk(event_flag == 1'b0, "R4", event_flag, 0);
        ticks(1);
        chk(event_flag == 1'b1, "R4", event_flag, 1);
        wr(2'd1, 8'h00); wr(2'd3, 8'h01); wr(2'd0, 8'd1);
        ticks(30); wr(2'd0, 8'd1); ticks(59);
        chk(event_flag == 1'b0, "R4", event_flag, 0);
        ticks(1);
        chk(event_flag == 1'b1, "R4", event_flag, 1);

        // R10 hold at zero after expiry; preset 0 never expires
        wr(2'd1, 8'h01); wr(2'd3, 8'h01);
        ticks(300);
        chk(event_flag == 1'b0, "R10", event_flag, 0);
        wr(2'd0, 8'd0); ticks(20);
        chk(event_flag == 1'b0, "R10", event_flag, 0);

        // R7 late enable gives no reset
        base = rst_cycles;
        wr(2'd0, 8'd2); ticks(2);
        chk(event_flag == 1'b1, "R7", event_flag, 1);
        wr(2'd2, 8'h02); idle(8);
        chk(rst_cycles == base, "R7", rst_cycles - base, 0);

        // R8 second expiry with flag still set gives no reset
        wr(2'd0, 8'd2); ticks(2); idle(8);
        chk(rst_cycles == base && event_flag, "R8", rst_cycles - base, 0);

        // R6 qualified rise gives one pulse of 4 cycles
        wr(2'd3, 8'h01); wr(2'd0, 8'd3); ticks(2);
        chk(sys_rst == 1'b0 && !event_flag, "R6", sys_rst, 0);
        ticks(1);
        chk(sys_rst == 1'b1 && event_flag, "R6", sys_rst, 1);
        idle(10);
        chk(rst_cycles - base == 4, "R6", rst_cycles - base, 4);

        // R9 clear semantics
        wr(2'd3, 8'hFE);
        chk(event_flag == 1'b1, "R9", event_flag, 1);
        rd(2'd3, v); chk(v == 8'h01, "R9", v, 1);
        wr(2'd3, 8'h01);
        chk(event_flag == 1'b0, "R9", event_flag, 0);
        rd(2'd3, v); chk(v == 8'h00, "R9", v, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule